// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

A synchronous single-port memory built for full bus use when reads and writes alternate. Every operation is launched by one rising clock edge that captures the address, the chip select, the operation type and the per-lane write mask. Write data does not come with its address. It arrives two enabled edges later, is held for one further enabled edge in a pending-write register, and is then committed to the array. A read returns registered data two enabled edges after its address. A read may directly follow a write with no idle cycle. Because the newest data can still sit in the pending register, every read is compared against it and merged lane by lane.

A stall input freezes the whole pipeline. While it is high, a clock edge does nothing: no stage advances, no write commits, and the output register and its drive state hold. The read-data drive enable is qualified by an output-enable input. It is turned off automatically for write, aborted-write and deselect slots.

Top module: `lw_sram`

## Requirements
- R1: After reset, `rd_drive` is low and no operation is in flight. The first enabled edge after reset launches no write or read that was not given.
- R2: On an enabled edge with `cs` high, `op_write`, `lane_wen` and `addr` are captured together. `op_write`=1 selects a write and `op_write`=0 a read. Bit i of `lane_wen` belongs to data bits [i*LANE_W +: LANE_W]. A read never turns into a write, or the reverse.
- R3: For a read captured at enabled edge k, `rd_data` holds the word at `addr` from enabled edge k+2 onward. With `oe` high, `rd_drive` is high.
- R4: For a write captured at enabled edge k, `wr_data` is sampled at enabled edge k+2. Only the lanes whose `lane_wen` bit was 1 at edge k are changed.
- R5: A write with `lane_wen` all zero is aborted. It changes no lane, and its output slot is not driven.
- R6: A read returns the data of all writes captured before it, including a write whose data is still pending and not yet in the array. Lanes are merged one by one, and the newest write wins.
- R7: With `stall` high, an edge is ignored. Nothing is captured or committed, and `rd_data` and `rd_drive` keep their values (while `oe` is unchanged).
- R8: `rd_drive` is high only when `oe` is high and the slot loaded last by an enabled edge was a read.
- R9: With `cs` low on an enabled edge, no operation is launched. The array is not changed, and that output slot is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | High: ignore this edge |
| cs | input | 1 | Chip select, high launches an operation |
| op_write | input | 1 | 1 = write, 0 = read |
| lane_wen | input | LANES | Per-lane write enables, active high |
| addr | input | ADDR_W | Word address |
| wr_data | input | LANES*LANE_W | Write data, two enabled edges after its address |
| oe | input | 1 | Output enable, active high |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_drive | output | 1 | High when the read-data bus is driven |

## Verification
Assertions check on every cycle several properties. A stall freezes the output register, the drive state and the pending write. A loaded read slot raises the output-valid flag, while write and aborted-write slots leave the bus off. An aborted write never becomes pending. A full-mask pending write that hits a read is forwarded into the output register. Other behaviours can only be shown by the bench's scenarios, which replay a shadow memory. These are correct data across partial-lane merges, the two-edge write-data lag combined with stalls, deselected writes that leave memory untouched, and back-to-back write/read alternation on the same address.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_kind_e;

  function automatic op_kind_e kind_of(input logic sel, input logic is_wr);
    if (!sel) return OP_IDLE;
    return is_wr ? OP_WRITE : OP_READ;
  endfunction
endpackage

// File: rtl/lw_sram_pipe.sv
module lw_sram_pipe
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              cs,
  input  logic              op_write,
  input  logic [LANES-1:0]  lane_wen,
  input  logic [ADDR_W-1:0] addr,
  output op_kind_e          s2_kind,
  output logic [LANES-1:0]  s2_mask,
  output logic [ADDR_W-1:0] s2_addr
);
  op_kind_e          s1_kind;
  logic [LANES-1:0]  s1_mask;
  logic [ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_kind <= OP_IDLE;
      s2_kind <= OP_IDLE;
      s1_mask <= '0;
      s2_mask <= '0;
      s1_addr <= '0;
      s2_addr <= '0;
    end else if (adv) begin
      s1_kind <= kind_of(cs, op_write);
      s1_mask <= lane_wen;
      s1_addr <= addr;
      s2_kind <= s1_kind;
      s2_mask <= s1_mask;
      s2_addr <= s1_addr;
    end
  end
endmodule

// File: rtl/lw_sram_pend.sv
module lw_sram_pend #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              cap,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [LANES-1:0]  cap_mask,
  input  logic [DW-1:0]     cap_data,
  output logic              pend_vld,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_mask,
  output logic [DW-1:0]     pend_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
      pend_data <= '0;
    end else if (adv) begin
      pend_vld <= cap;
      if (cap) begin
        pend_addr <= cap_addr;
        pend_mask <= cap_mask;
        pend_data <= cap_data;
      end
    end
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wmask[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              cs,
  input  logic              op_write,
  input  logic [LANES-1:0]  lane_wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              oe,
  output logic [DW-1:0]     rd_data,
  output logic              rd_drive
);
  // lane-by-lane overlay of pending bytes onto array bytes
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] base,
                                               input logic [DW-1:0] over,
                                               input logic [LANES-1:0] pick);
    logic [DW-1:0] r;
    r = base;
    for (int i = 0; i < LANES; i++)
      if (pick[i]) r[i*LANE_W +: LANE_W] = over[i*LANE_W +: LANE_W];
    return r;
  endfunction

  logic              adv;
  op_kind_e          s2_kind;
  logic [LANES-1:0]  s2_mask;
  logic [ADDR_W-1:0] s2_addr;
  logic              pend_cap;
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_mask;
  logic [DW-1:0]     pend_data;
  logic              commit_fire;
  logic [DW-1:0]     arr_rdata;
  logic              pend_hit;
  logic [DW-1:0]     read_word;
  logic              out_vld;
  logic [DW-1:0]     rdata_q;

  assign adv         = !stall;
  assign pend_cap    = (s2_kind == OP_WRITE) && (|s2_mask);
  assign commit_fire = adv && pend_vld;
  assign pend_hit    = pend_vld && (pend_addr == s2_addr);
  assign read_word   = lane_merge(arr_rdata, pend_data, pend_hit ? pend_mask : '0);

  lw_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cs(cs), .op_write(op_write),
    .lane_wen(lane_wen), .addr(addr),
    .s2_kind(s2_kind), .s2_mask(s2_mask), .s2_addr(s2_addr)
  );

  lw_sram_pend #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cap(pend_cap),
    .cap_addr(s2_addr), .cap_mask(s2_mask), .cap_data(wr_data),
    .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_mask(pend_mask),
    .pend_data(pend_data)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(commit_fire), .waddr(pend_addr), .wmask(pend_mask),
    .wdata(pend_data), .raddr(s2_addr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      rdata_q <= '0;
    end else if (adv) begin
      out_vld <= (s2_kind == OP_READ);
      if (s2_kind == OP_READ) rdata_q <= read_word;
    end
  end

  assign rd_data  = rdata_q;
  assign rd_drive = oe && out_vld;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              oe,
  input logic              adv,
  input op_kind_e          s2_kind,
  input logic [LANES-1:0]  s2_mask,
  input logic [ADDR_W-1:0] s2_addr,
  input logic              pend_vld,
  input logic [ADDR_W-1:0] pend_addr,
  input logic [LANES-1:0]  pend_mask,
  input logic [DW-1:0]     pend_data,
  input logic              out_vld,
  input logic [DW-1:0]     rdata_q,
  input logic              rd_drive
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !rd_drive && !pend_vld);

  assert_read_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_kind == OP_READ) |=> out_vld);

  assert_abort_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_kind == OP_WRITE && s2_mask == '0) |=> !pend_vld && !rd_drive);

  assert_forward_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_kind == OP_READ && pend_vld && pend_addr == s2_addr && (&pend_mask))
    |=> rdata_q == $past(pend_data));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(rdata_q) && $stable(out_vld) && $stable(pend_vld));

  assert_write_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_kind != OP_READ) |=> !rd_drive);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> oe);
endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .oe(oe), .adv(adv),
  .s2_kind(s2_kind), .s2_mask(s2_mask), .s2_addr(s2_addr),
  .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_mask(pend_mask),
  .pend_data(pend_data), .out_vld(out_vld), .rdata_q(rdata_q),
  .rd_drive(rd_drive)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int AW = 4;
  localparam int L  = 4;
  localparam int LW = 9;
  localparam int DW = L * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, cs = 1'b0, op_write = 1'b0, oe = 1'b0;
  logic [L-1:0]  lane_wen = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  lw_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .cs(cs), .op_write(op_write),
    .lane_wen(lane_wen), .addr(addr), .wr_data(wr_data), .oe(oe),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R3";

  logic [DW-1:0] shadow [1 << AW];
  // history of launched ops: index 1 = one enabled edge ago, 2 = two ago
  logic          h_v [1:2];
  logic          h_w [1:2];
  logic [L-1:0]  h_m [1:2];
  logic [AW-1:0] h_a [1:2];
  logic          exp_vld = 1'b0;
  logic [DW-1:0] exp_data = '0;

  function automatic logic [DW-1:0] apply_lanes(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w,
                                                input logic [L-1:0] m);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < L; i++)
      if (m[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  task automatic check_outputs();
    logic exp_en;
    exp_en = oe && exp_vld;
    checks++;
    if (rd_drive !== exp_en) begin
      errors++;
      $display("FAIL %s rd_drive got %0b exp %0b", cur_tag, rd_drive, exp_en);
    end
    if (exp_en) begin
      checks++;
      if (rd_data !== exp_data) begin
        errors++;
        $display("FAIL %s rd_data got %h exp %h", cur_tag, rd_data, exp_data);
      end
    end
  endtask

  task automatic step(input logic st, input logic sl, input logic w,
                      input logic [L-1:0] m, input logic [AW-1:0] a, input logic o);
    logic [DW-1:0] d;
    @(negedge clk);
    check_outputs();
    d = rnd_word();
    stall = st; cs = sl; op_write = w; lane_wen = m; addr = a; oe = o;
    wr_data = d;
    @(posedge clk);
    #1;
    if (!st) begin
      if (h_v[2] && h_w[2]) shadow[h_a[2]] = apply_lanes(shadow[h_a[2]], d, h_m[2]);
      exp_vld = h_v[2] && !h_w[2];
      if (exp_vld) exp_data = shadow[h_a[2]];
      h_v[2] = h_v[1]; h_w[2] = h_w[1]; h_m[2] = h_m[1]; h_a[2] = h_a[1];
      h_v[1] = sl;     h_w[1] = w;      h_m[1] = m;      h_a[1] = a;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a_0c33));
    for (int i = 0; i < 2; i++) begin
      h_v[i+1] = 1'b0; h_w[i+1] = 1'b0; h_m[i+1] = '0; h_a[i+1] = '0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    oe = 1'b1;
    // R1: after reset with oe high, nothing is driven
    cur_tag = "R1";
    @(negedge clk);
    check_outputs();
    // R4: fill every word with full-width writes, back to back
    cur_tag = "R4";
    for (int i = 0; i < (1 << AW); i++) step(1'b0, 1'b1, 1'b1, '1, AW'(i), 1'b1);
    idle(3);
    for (int i = 0; i < (1 << AW); i++) step(1'b0, 1'b1, 1'b0, '0, AW'(i), 1'b1);
    idle(3);
    // R6: partial write then an immediate read of the same word (pending merge)
    cur_tag = "R6";
    step(1'b0, 1'b1, 1'b1, 4'b0101, 4'd3, 1'b1);
    step(1'b0, 1'b1, 1'b0, '0, 4'd3, 1'b1);
    step(1'b0, 1'b1, 1'b1, 4'b1000, 4'd3, 1'b1);
    step(1'b0, 1'b1, 1'b1, 4'b0010, 4'd3, 1'b1);
    step(1'b0, 1'b1, 1'b0, '0, 4'd3, 1'b1);
    step(1'b0, 1'b1, 1'b0, '0, 4'd3, 1'b1);
    idle(3);
    // R5: aborted write leaves the word unchanged and the slot undriven
    cur_tag = "R5";
    step(1'b0, 1'b1, 1'b1, 4'b0000, 4'd5, 1'b1);
    step(1'b0, 1'b1, 1'b0, '0, 4'd5, 1'b1);
    idle(3);
    // R9: deselected write with full mask changes nothing
    cur_tag = "R9";
    step(1'b0, 1'b0, 1'b1, '1, 4'd2, 1'b1);
    step(1'b0, 1'b1, 1'b0, '0, 4'd2, 1'b1);
    idle(3);
    // R7: stalls inside a write and a read; data still lags by enabled edges
    cur_tag = "R7";
    step(1'b0, 1'b1, 1'b1, '1, 4'd6, 1'b1);
    step(1'b1, 1'b1, 1'b0, '0, 4'd9, 1'b1);
    step(1'b0, 1'b1, 1'b0, '0, 4'd6, 1'b1);
    step(1'b1, 1'b0, 1'b1, '1, 4'd6, 1'b1);
    step(1'b1, 1'b0, 1'b1, '1, 4'd6, 1'b1);
    step(1'b0, 1'b0, 1'b0, '0, 4'd0, 1'b1);
    step(1'b1, 1'b1, 1'b1, '1, 4'd6, 1'b1);
    step(1'b1, 1'b1, 1'b1, '1, 4'd6, 1'b1);
    idle(3);
    // R8: oe high during writes, oe low during reads
    cur_tag = "R8";
    step(1'b0, 1'b1, 1'b1, '1, 4'd8, 1'b1);
    step(1'b0, 1'b1, 1'b1, 4'b0011, 4'd8, 1'b1);
    step(1'b0, 1'b1, 1'b0, '0, 4'd8, 1'b0);
    step(1'b0, 1'b1, 1'b0, '0, 4'd8, 1'b0);
    step(1'b0, 1'b1, 1'b0, '0, 4'd8, 1'b1);
    idle(3);
    // R2/R3: constrained random mix on a narrow address range
    cur_tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      if (i == 2000) cur_tag = "R3";
      step(($urandom % 8) == 0, ($urandom % 8) != 0, $urandom % 2,
           L'($urandom), AW'($urandom % 4), ($urandom % 6) != 0);
    end
    idle(3);
    @(negedge clk);
    check_outputs();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule